// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This controller moves a processor subsystem out of normal operation into one of three sleep depths and brings it back. A wait-for-interrupt request from the core starts the move. Three control inputs pick the depth. The deep select chooses between a light sleep and the deeper modes. The power-down select chooses between retention and full core shutdown. A third input asks for the low-power regulator while the core is parked. The block drives the core clock gate, the oscillator enable, the regulator mode and the core power-domain enable. It also reports its state as a small code.

The controller watches a separate set of wake sources for each depth. Light sleep ends on any interrupt. Retention sleep ends on any enabled event line. Shutdown ends only on a rising edge at an enabled wake pin, a real-time-clock event, an external reset or a watchdog reset. Shutdown exit passes through a boot state that models the core re-entering through reset.

Each resume takes a fixed number of cycles, set by parameters. The count grows when the regulator was in low-power mode. It also grows when the voltage reference was switched off and the core must wait for it, unless the skip-wait option is set. A separate low-power run mode keeps the core clocked on the low-power regulator. A status output shows when that regulator has not yet handed back to the main one. Oscillators, regulators and the reference appear only as handshake signals and timers.

Top module: `lpm_seq`

## Requirements
- R1: After reset, pm_state is 0 (run). core_clk_en, osc_en, core_pwr_en and vref_rdy are 1. reg_mode is 0 (main). wake_flag, stby_flag, clk_fallback and lpreg_busy are 0.
- R2: In run, a wfi_req sampled with deep_sel=0 moves pm_state to 1 (sleep) at that clock edge. In sleep, core_clk_en=0, osc_en=1 and core_pwr_en=1, and reg_mode is 1 if deep_lpreg was 1 at entry, else 0. Event lines have no effect in sleep, and irq_any starts the wake.
- R3: A wfi_req with deep_sel=1 and pdown_sel=0 moves pm_state to 2 (stop). In stop, core_clk_en=0, osc_en=0 and core_pwr_en=1, and reg_mode follows deep_lpreg as in R2. irq_any and masked event lines have no effect in stop; a line with its evt_mask bit set starts the wake.
- R4: A wfi_req with deep_sel=1 and pdown_sel=1 moves pm_state to 3 (standby) only if wake_flag is 0; otherwise pm_state stays 0. In standby, core_pwr_en=0, osc_en=0 and reg_mode is 2 (off).
- R5: Standby is left only on a rising edge of a wk_pin bit whose wk_pin_en bit is set, rtc_evt, ext_rst or wdg_rst. irq_any, event lines and disabled pins are ignored there. The exit enters pm_state 5 (boot) and sets stby_flag, which stby_flag_clr clears.
- R6: A wake from sleep or stop enters pm_state 4 (resume). core_clk_en returns N edges after the wake edge, where N = T_WAKE, plus T_REGLP if deep_lpreg was set at entry, plus T_VREF when leaving stop with ref_off_lp set and skip_ref_wait clear at entry.
- R7: A standby exit returns core_clk_en T_BOOT edges after the exit edge, plus T_VREF when ref_off_lp was set and skip_ref_wait clear at entry.
- R8: If ref_off_lp is set when entering stop or standby, vref_rdy drops on entry and returns T_VREF edges after the wake edge. Otherwise, and always for sleep, vref_rdy stays 1.
- R9: wake_flag is set by an enabled wake-pin rising edge or by rtc_evt, in any state. wake_flag_clr clears it, and a set in the same cycle wins over the clear.
- R10: clk_fallback is 0 after reset and is set when the block leaves stop. Leaving sleep leaves it unchanged.
- R11: Low-power run starts only on a rising edge of run_lp_en while run_lpreg is already 1 and vcore_rng is 2'b10 (middle range). While it is active, reg_mode is 1. It ends when run_lp_en is 0.
- R12: lpreg_busy is 1 while low-power run is active. After the run ends it stays 1 until main_reg_rdy is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt request from the core |
| deep_sel | input | 1 | Select a deep mode (stop or standby) |
| pdown_sel | input | 1 | In deep mode, select standby over stop |
| deep_lpreg | input | 1 | Use the low-power regulator in sleep or stop |
| ref_off_lp | input | 1 | Switch the voltage reference off in stop or standby |
| skip_ref_wait | input | 1 | Resume without waiting for the reference |
| run_lpreg | input | 1 | Low-power regulator bit for low-power run |
| run_lp_en | input | 1 | Low-power run request bit |
| vcore_rng | input | 2 | Core voltage range (2'b10 = middle) |
| main_reg_rdy | input | 1 | Main regulator ready handshake |
| irq_any | input | 1 | Any pending interrupt |
| evt_line | input | NEVT | Event lines |
| evt_mask | input | NEVT | Event line enables |
| wk_pin | input | NPIN | Wake pins |
| wk_pin_en | input | NPIN | Wake pin enables |
| rtc_evt | input | 1 | Real-time-clock alarm, wakeup, tamper or timestamp event |
| ext_rst | input | 1 | External reset request (standby exit) |
| wdg_rst | input | 1 | Watchdog reset request (standby exit) |
| wake_flag_clr | input | 1 | Clear wake_flag |
| stby_flag_clr | input | 1 | Clear stby_flag |
| pm_state | output | 3 | 0 run, 1 sleep, 2 stop, 3 standby, 4 resume, 5 boot |
| core_clk_en | output | 1 | Core clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| core_pwr_en | output | 1 | Core power-domain enable |
| reg_mode | output | 2 | Regulator mode: 0 main, 1 low-power, 2 off |
| vref_rdy | output | 1 | Voltage reference ready |
| clk_fallback | output | 1 | System clock forced to the internal low-speed oscillator |
| wake_flag | output | 1 | Wake event seen |
| stby_flag | output | 1 | Resumed from standby |
| lpreg_busy | output | 1 | Low-power regulator still in use |

## Verification
The hardest case to reach is the pair of timers running together on a resume. The case needs the reference switched off, the skip-wait option set or clear, and the low-power regulator chosen or not, all at the moment of entry, and the core clock and the reference-ready output must then rise in the right order. The bench sweeps every combination of those three bits through sleep and stop. It also sweeps both reference bits against each of the four standby exit sources. In each run it counts edges from the wake stimulus until each output rises. Before every standby entry it clears the wake flag, since a left-over flag from a pin or clock event would block entry. One case sets the flag on purpose to show that block.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_STOP  = 3'd2,
    ST_STBY  = 3'd3,
    ST_WAKE  = 3'd4,
    ST_BOOT  = 3'd5
  } pm_state_e;

  typedef enum logic [1:0] {
    REG_MAIN = 2'd0,
    REG_LP   = 2'd1,
    REG_OFF  = 2'd2
  } reg_mode_e;

  localparam logic [1:0] RNG_MID = 2'b10;

  // Cycles spent parked in resume or boot before the core clock returns.
  function automatic int unsigned resume_cycles(
      input int unsigned base,
      input int unsigned lp_extra,
      input int unsigned ref_extra,
      input logic        use_lp,
      input logic        use_ref);
    int unsigned total;
    total = base;
    if (use_lp)  total = total + lp_extra;
    if (use_ref) total = total + ref_extra;
    return total;
  endfunction

endpackage

// File: rtl/lpm_countdown.sv
`timescale 1ns/1ps
module lpm_countdown #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  // R6
  countdown_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val > CW'(1)) |=> (busy && !done));

endmodule

// File: rtl/lpm_wake_src.sv
`timescale 1ns/1ps
module lpm_wake_src #(
  parameter int NPIN = 3,
  parameter int NEVT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] wk_pin,
  input  logic [NPIN-1:0] wk_pin_en,
  input  logic [NEVT-1:0] evt_line,
  input  logic [NEVT-1:0] evt_mask,
  input  logic            rtc_evt,
  input  logic            ext_rst,
  input  logic            wdg_rst,
  output logic [NPIN-1:0] pin_rise,
  output logic            evt_hit,
  output logic            stby_wake,
  output logic            wake_set
);
  logic [NPIN-1:0] pin_d;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_d[g] <= 1'b0;
      else        pin_d[g] <= wk_pin[g];
    end
    assign pin_rise[g] = wk_pin[g] & ~pin_d[g] & wk_pin_en[g];
  end

  assign evt_hit   = |(evt_line & evt_mask);
  assign wake_set  = (|pin_rise) | rtc_evt;
  assign stby_wake = wake_set | ext_rst | wdg_rst;

endmodule

// File: rtl/lpm_seq.sv
`timescale 1ns/1ps
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int NPIN    = 3,
  parameter int NEVT    = 4,
  parameter int T_WAKE  = 2,
  parameter int T_REGLP = 3,
  parameter int T_VREF  = 6,
  parameter int T_BOOT  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wfi_req,
  input  logic            deep_sel,
  input  logic            pdown_sel,
  input  logic            deep_lpreg,
  input  logic            ref_off_lp,
  input  logic            skip_ref_wait,
  input  logic            run_lpreg,
  input  logic            run_lp_en,
  input  logic [1:0]      vcore_rng,
  input  logic            main_reg_rdy,
  input  logic            irq_any,
  input  logic [NEVT-1:0] evt_line,
  input  logic [NEVT-1:0] evt_mask,
  input  logic [NPIN-1:0] wk_pin,
  input  logic [NPIN-1:0] wk_pin_en,
  input  logic            rtc_evt,
  input  logic            ext_rst,
  input  logic            wdg_rst,
  input  logic            wake_flag_clr,
  input  logic            stby_flag_clr,
  output logic [2:0]      pm_state,
  output logic            core_clk_en,
  output logic            osc_en,
  output logic            core_pwr_en,
  output logic [1:0]      reg_mode,
  output logic            vref_rdy,
  output logic            clk_fallback,
  output logic            wake_flag,
  output logic            stby_flag,
  output logic            lpreg_busy
);
  localparam int T_MAX = T_WAKE + T_REGLP + T_VREF + T_BOOT;
  localparam int CW    = $clog2(T_MAX + 1);

  pm_state_e state, nxt;
  reg_mode_e reg_sel;
  logic lp_lat, ulp_lat, fast_lat;
  logic tmr_load, tmr_busy, tmr_done;
  logic [CW-1:0] tmr_val;
  logic ref_load, ref_busy, ref_done, vref_ok;
  logic [NPIN-1:0] pin_rise;
  logic evt_hit, stby_wake, wake_set;
  logic lprun_act, lprun_nxt, run_lp_en_d;
  logic enter_lp, stop_exit, stby_exit, ref_drop;

  lpm_wake_src #(.NPIN(NPIN), .NEVT(NEVT)) u_wake_src (
    .clk(clk), .rst_n(rst_n), .wk_pin(wk_pin), .wk_pin_en(wk_pin_en),
    .evt_line(evt_line), .evt_mask(evt_mask), .rtc_evt(rtc_evt),
    .ext_rst(ext_rst), .wdg_rst(wdg_rst), .pin_rise(pin_rise),
    .evt_hit(evt_hit), .stby_wake(stby_wake), .wake_set(wake_set));

  lpm_countdown #(.CW(CW)) u_resume_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .busy(tmr_busy), .done(tmr_done));

  lpm_countdown #(.CW(CW)) u_ref_tmr (
    .clk(clk), .rst_n(rst_n), .load(ref_load), .load_val(CW'(T_VREF)),
    .busy(ref_busy), .done(ref_done));

  // Mode selection and wake decode
  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_load = 1'b0;
    case (state)
      ST_RUN: if (wfi_req) begin
        if (!deep_sel)       nxt = ST_SLEEP;
        else if (!pdown_sel) nxt = ST_STOP;
        else if (!wake_flag) nxt = ST_STBY;
      end
      ST_SLEEP: if (irq_any) begin
        nxt      = ST_WAKE;
        tmr_load = 1'b1;
        tmr_val  = CW'(resume_cycles(T_WAKE, T_REGLP, T_VREF, lp_lat, 1'b0));
      end
      ST_STOP: if (evt_hit) begin
        nxt      = ST_WAKE;
        tmr_load = 1'b1;
        tmr_val  = CW'(resume_cycles(T_WAKE, T_REGLP, T_VREF, lp_lat,
                                     ulp_lat && !fast_lat));
        ref_load = ulp_lat;
      end
      ST_STBY: if (stby_wake) begin
        nxt      = ST_BOOT;
        tmr_load = 1'b1;
        tmr_val  = CW'(resume_cycles(T_BOOT, T_REGLP, T_VREF, 1'b0,
                                     ulp_lat && !fast_lat));
        ref_load = ulp_lat;
      end
      ST_WAKE, ST_BOOT: if (tmr_done) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  assign enter_lp  = (state == ST_RUN) && (nxt != ST_RUN);
  assign stop_exit = (state == ST_STOP) && (nxt == ST_WAKE);
  assign stby_exit = (state == ST_STBY) && (nxt == ST_BOOT);
  assign ref_drop  = enter_lp && ref_off_lp && (nxt == ST_STOP || nxt == ST_STBY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      lp_lat   <= 1'b0;
      ulp_lat  <= 1'b0;
      fast_lat <= 1'b0;
    end else begin
      state <= nxt;
      if (enter_lp) begin
        lp_lat   <= deep_lpreg;
        ulp_lat  <= ref_off_lp;
        fast_lat <= skip_ref_wait;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vref_ok      <= 1'b1;
      clk_fallback <= 1'b0;
      wake_flag    <= 1'b0;
      stby_flag    <= 1'b0;
    end else begin
      if (ref_drop)      vref_ok <= 1'b0;
      else if (ref_done) vref_ok <= 1'b1;
      if (stop_exit) clk_fallback <= 1'b1;
      if (wake_set)           wake_flag <= 1'b1;
      else if (wake_flag_clr) wake_flag <= 1'b0;
      if (stby_exit)          stby_flag <= 1'b1;
      else if (stby_flag_clr) stby_flag <= 1'b0;
    end
  end

  // Low-power run: ordered entry, reverse exit, handback to main regulator
  always_comb begin
    lprun_nxt = lprun_act;
    if (!run_lp_en)
      lprun_nxt = 1'b0;
    else if (state == ST_RUN && !run_lp_en_d && run_lpreg && vcore_rng == RNG_MID)
      lprun_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lprun_act   <= 1'b0;
      run_lp_en_d <= 1'b0;
      lpreg_busy  <= 1'b0;
    end else begin
      lprun_act   <= lprun_nxt;
      run_lp_en_d <= run_lp_en;
      lpreg_busy  <= lprun_nxt | (lpreg_busy & ~main_reg_rdy);
    end
  end

  always_comb begin
    case (state)
      ST_STBY:           reg_sel = REG_OFF;
      ST_SLEEP, ST_STOP: reg_sel = (lp_lat || lprun_act) ? REG_LP : REG_MAIN;
      ST_RUN:            reg_sel = lprun_act ? REG_LP : REG_MAIN;
      default:           reg_sel = REG_MAIN;
    endcase
  end

  assign pm_state    = state;
  assign core_clk_en = (state == ST_RUN);
  assign osc_en      = !(state == ST_STOP || state == ST_STBY);
  assign core_pwr_en = (state != ST_STBY);
  assign reg_mode    = reg_sel;
  assign vref_rdy    = vref_ok;

  // R4
  stby_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && wfi_req && deep_sel && pdown_sel && wake_flag) |=> (state == ST_RUN));
  // R5
  stby_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stby_flag) |-> ($past(state) == ST_STBY));
  // R8
  ref_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !vref_ok) |-> fast_lat);
  // R9
  wake_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(wake_set));
  // R10
  fallback_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_fallback) |-> ($past(state) == ST_STOP));
  // R11
  lprun_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lprun_act) |-> ($past(run_lpreg) && $past(vcore_rng) == RNG_MID));
  // R12
  lpreg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lpreg_busy) |-> $past(main_reg_rdy));

endmodule

// File: tb/tb_lpm_seq.sv
`timescale 1ns/1ps
module tb_lpm_seq;
  localparam int PINS = 3, EVTS = 4;
  localparam int TW = 2, TR = 3, TV = 6, TB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi_req = 0, deep_sel = 0, pdown_sel = 0, deep_lpreg = 0;
  logic ref_off_lp = 0, skip_ref_wait = 0, run_lpreg = 0, run_lp_en = 0;
  logic [1:0] vcore_rng = 2'b10;
  logic main_reg_rdy = 0, irq_any = 0;
  logic [EVTS-1:0] evt_line = '0, evt_mask = 4'b0010;
  logic [PINS-1:0] wk_pin = '0, wk_pin_en = 3'b101;
  logic rtc_evt = 0, ext_rst = 0, wdg_rst = 0, wake_flag_clr = 0, stby_flag_clr = 0;
  logic [2:0] pm_state;
  logic core_clk_en, osc_en, core_pwr_en, vref_rdy, clk_fallback;
  logic wake_flag, stby_flag, lpreg_busy;
  logic [1:0] reg_mode;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lpm_seq #(.NPIN(PINS), .NEVT(EVTS), .T_WAKE(TW), .T_REGLP(TR),
            .T_VREF(TV), .T_BOOT(TB)) dut (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .deep_sel(deep_sel),
    .pdown_sel(pdown_sel), .deep_lpreg(deep_lpreg), .ref_off_lp(ref_off_lp),
    .skip_ref_wait(skip_ref_wait), .run_lpreg(run_lpreg), .run_lp_en(run_lp_en),
    .vcore_rng(vcore_rng), .main_reg_rdy(main_reg_rdy), .irq_any(irq_any),
    .evt_line(evt_line), .evt_mask(evt_mask), .wk_pin(wk_pin), .wk_pin_en(wk_pin_en),
    .rtc_evt(rtc_evt), .ext_rst(ext_rst), .wdg_rst(wdg_rst),
    .wake_flag_clr(wake_flag_clr), .stby_flag_clr(stby_flag_clr),
    .pm_state(pm_state), .core_clk_en(core_clk_en), .osc_en(osc_en),
    .core_pwr_en(core_pwr_en), .reg_mode(reg_mode), .vref_rdy(vref_rdy),
    .clk_fallback(clk_fallback), .wake_flag(wake_flag), .stby_flag(stby_flag),
    .lpreg_busy(lpreg_busy));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_low(input bit dp, input bit pd, input bit lp, input bit ulp, input bit fast);
    @(negedge clk);
    deep_sel = dp; pdown_sel = pd; deep_lpreg = lp;
    ref_off_lp = ulp; skip_ref_wait = fast; wfi_req = 1;
    @(negedge clk);
    wfi_req = 0;
  endtask

  task automatic drive_src(input int src, input logic v);
    case (src)
      0: irq_any = v;
      1: evt_line[1] = v;
      2: wk_pin[0] = v;
      3: rtc_evt = v;
      4: ext_rst = v;
      default: wdg_rst = v;
    endcase
  endtask

  // Counts edges from the wake stimulus until core clock and reference return.
  task automatic wake_run(input int src, output int c_n, output int v_n, output int s1);
    @(negedge clk);
    drive_src(src, 1'b1);
    c_n = 0; v_n = 0; s1 = -1;
    for (int n = 1; n <= 200; n++) begin
      @(posedge clk); #1;
      if (n == 1) begin drive_src(src, 1'b0); s1 = pm_state; end
      if (v_n == 0 && vref_rdy) v_n = n;
      if (c_n == 0 && core_clk_en) c_n = n;
      if (c_n != 0 && v_n != 0) break;
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1; @(negedge clk); sig = 0;
  endtask

  initial begin
    int c_n, v_n, s1, exp_c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pm_state", pm_state, 0);
    chk("R1 core_clk_en", core_clk_en, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 core_pwr_en", core_pwr_en, 1);
    chk("R1 reg_mode", reg_mode, 0);
    chk("R1 vref_rdy", vref_rdy, 1);
    chk("R1 flags", {wake_flag, stby_flag, clk_fallback, lpreg_busy}, 0);

    // R9 and R4: wake flag blocks standby entry
    pulse(rtc_evt);
    chk("R9 set by rtc", wake_flag, 1);
    go_low(1, 1, 0, 0, 0);
    chk("R4 standby refused with wake flag", pm_state, 0);
    @(negedge clk); rtc_evt = 1; wake_flag_clr = 1;
    @(negedge clk); rtc_evt = 0; wake_flag_clr = 0;
    chk("R9 set beats clear", wake_flag, 1);
    pulse(wake_flag_clr);
    chk("R9 cleared", wake_flag, 0);

    // Sleep sweep
    for (int k = 0; k < 8; k++) begin
      bit lp, ulp, fast;
      lp = k[0]; ulp = k[1]; fast = k[2];
      go_low(0, 0, lp, ulp, fast);
      chk("R2 sleep state", pm_state, 1);
      chk("R2 sleep outputs", {core_clk_en, osc_en, core_pwr_en}, 3'b011);
      chk("R2 sleep regulator", reg_mode, int'(lp));
      chk("R8 sleep vref kept", vref_rdy, 1);
      @(negedge clk); evt_line[1] = 1;
      @(negedge clk); @(negedge clk); evt_line[1] = 0;
      chk("R2 event ignored in sleep", pm_state, 1);
      wake_run(0, c_n, v_n, s1);
      chk("R6 sleep resume state", s1, 4);
      chk("R6 sleep latency", c_n, 1 + TW + (lp ? TR : 0));
      chk("R8 sleep vref", v_n, 1);
      chk("R10 fallback after sleep", clk_fallback, 0);
    end

    // Stop sweep
    for (int k = 0; k < 8; k++) begin
      bit lp, ulp, fast;
      lp = k[0]; ulp = k[1]; fast = k[2];
      go_low(1, 0, lp, ulp, fast);
      chk("R3 stop state", pm_state, 2);
      chk("R3 stop outputs", {core_clk_en, osc_en, core_pwr_en}, 3'b001);
      chk("R3 stop regulator", reg_mode, int'(lp));
      chk("R8 stop vref entry", vref_rdy, ulp ? 0 : 1);
      @(negedge clk); irq_any = 1; evt_line[0] = 1;
      @(negedge clk); @(negedge clk); irq_any = 0; evt_line[0] = 0;
      chk("R3 irq and masked event ignored", pm_state, 2);
      wake_run(1, c_n, v_n, s1);
      exp_c = 1 + TW + (lp ? TR : 0) + ((ulp && !fast) ? TV : 0);
      chk("R6 stop resume state", s1, 4);
      chk("R6 stop latency", c_n, exp_c);
      chk("R8 stop vref latency", v_n, ulp ? 1 + TV : 1);
      chk("R10 fallback after stop", clk_fallback, 1);
    end

    // Standby sweep over exit sources and reference settings
    for (int src = 2; src <= 5; src++) begin
      for (int k = 0; k < 4; k++) begin
        bit ulp, fast;
        ulp = k[0]; fast = k[1];
        pulse(wake_flag_clr);
        pulse(stby_flag_clr);
        chk("R5 standby flag cleared", stby_flag, 0);
        go_low(1, 1, 0, ulp, fast);
        chk("R4 standby state", pm_state, 3);
        chk("R4 standby outputs", {core_clk_en, osc_en, core_pwr_en}, 3'b000);
        chk("R4 standby regulator", reg_mode, 2);
        chk("R8 standby vref entry", vref_rdy, ulp ? 0 : 1);
        @(negedge clk); irq_any = 1; evt_line[1] = 1; wk_pin[1] = 1;
        @(negedge clk); @(negedge clk); irq_any = 0; evt_line[1] = 0; wk_pin[1] = 0;
        chk("R5 other sources ignored", pm_state, 3);
        chk("R9 disabled pin no flag", wake_flag, 0);
        wake_run(src, c_n, v_n, s1);
        chk("R5 boot state", s1, 5);
        chk("R7 boot latency", c_n, 1 + TB + ((ulp && !fast) ? TV : 0));
        chk("R8 standby vref latency", v_n, ulp ? 1 + TV : 1);
        chk("R5 standby flag set", stby_flag, 1);
        chk("R9 wake flag by source", wake_flag, (src == 2 || src == 3) ? 1 : 0);
      end
    end

    // R11 and R12: low-power run
    @(negedge clk); run_lpreg = 0; vcore_rng = 2'b10; run_lp_en = 1;
    @(negedge clk);
    chk("R11 wrong order refused", reg_mode, 0);
    run_lpreg = 1;
    @(negedge clk);
    chk("R11 late regulator bit refused", reg_mode, 0);
    run_lp_en = 0; vcore_rng = 2'b01;
    @(negedge clk); run_lp_en = 1;
    @(negedge clk);
    chk("R11 wrong range refused", reg_mode, 0);
    chk("R12 idle busy", lpreg_busy, 0);
    run_lp_en = 0; vcore_rng = 2'b10;
    @(negedge clk); run_lp_en = 1;
    @(negedge clk);
    chk("R11 entered", reg_mode, 1);
    chk("R12 busy in run", lpreg_busy, 1);
    run_lp_en = 0;
    @(negedge clk);
    chk("R11 exit", reg_mode, 0);
    repeat (3) @(negedge clk);
    chk("R12 busy held", lpreg_busy, 1);
    main_reg_rdy = 1; run_lpreg = 0;
    @(negedge clk);
    chk("R12 released", lpreg_busy, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule